// File: doc/BRIEF.md
# Deep-Sleep Clock and Oscillator Controller

This block holds a 32-bit deep-sleep clock configuration word. From that word, the current power mode and two system inputs, it makes two decisions. The first is whether the main crystal oscillator is powered in the present mode. The second is which clock source code and divider value the clock tree uses while the chip is in deep sleep. It also drives the enable for the internal precision oscillator.

There is one case where the configured deep-sleep source cannot safely be used: the main oscillator is asked for, but it is not the run/sleep source. If the internal oscillator stays powered in deep sleep, the block substitutes it. If the internal oscillator would be powered down, the block raises a hazard flag, because the chip could not leave deep sleep cleanly.

The deep-sleep source and divider are captured once, on the clock edge that sees the mode input enter deep sleep. They then hold until the next entry. The oscillators, the glitch-free clock switch and the divider counter are outside this block.

Top module: `dslp_clk_ctrl`

## Requirements
- R1: After reset the configuration word reads 0x0000_0000, `ds_src_o` and `ds_div_o` are 0, `exit_hazard_o` is 0, and in run mode with `mosc_pd_i`=0 both oscillator enables are 1.
- R2: A write stores only bits 9:0 (divider), 23:20 (source select), 30 (main-oscillator keep-alive) and 31 (internal-oscillator deep power-down). All other bits are ignored and read as 0, so writing 0xFFFF_FFFF reads back 0xC0F0_03FF.
- R3: With `mosc_pd_i`=0 and bit 30 = 0, `main_osc_en_o` is 1 in run and sleep modes. In deep sleep (`mode_i`=2'b10) it is 1 only when the source select equals 0x3.
- R4: With `mosc_pd_i`=0 and bit 30 = 1, `main_osc_en_o` is 1 in every mode.
- R5: With `mosc_pd_i`=1 and bit 30 = 0, `main_osc_en_o` is 0 in every mode, including when the source select is 0x3.
- R6: With `mosc_pd_i`=1 and bit 30 = 1, `main_osc_en_o` is 1 in every mode; the keep-alive bit overrides the power-down request.
- R7: `int_osc_en_o` is 0 only when bit 31 = 1 and the mode is deep sleep. It is 1 in run and sleep modes whatever bit 31 holds.
- R8: `ds_src_o` and `ds_div_o` load on the clock edge at which `mode_i` is first sampled as deep sleep after any other mode. Configuration writes made while in deep sleep, or after leaving it, do not change them until the next entry.
- R9: If the source select is 0x3 (main oscillator), `rs_main_i`=0 and bit 31 = 0, the captured `ds_src_o` is 0x0 (internal oscillator) instead of 0x3.
- R10: `exit_hazard_o` is 1, combinationally and in any mode, exactly when the source select is 0x3, `rs_main_i`=0 and bit 31 = 1. The source captured in that state stays 0x3.
- R11: Mode code 2'b11 is treated as run mode: the main oscillator follows the run rules and the internal oscillator stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, reserved bits zero |
| mode_i | input | 2 | Power mode: 00 run, 01 sleep, 10 deep sleep, 11 run |
| mosc_pd_i | input | 1 | Main-oscillator power-down request |
| rs_main_i | input | 1 | 1 when the main oscillator is the run/sleep clock source |
| main_osc_en_o | output | 1 | Main oscillator power enable |
| int_osc_en_o | output | 1 | Internal precision oscillator enable |
| ds_src_o | output | 4 | Captured effective deep-sleep source code |
| ds_div_o | output | 10 | Captured deep-sleep divider |
| exit_hazard_o | output | 1 | Deep-sleep exit would fail with the present setup |

## Verification
The bench walks all four combinations of the power-down request and the keep-alive bit through every mode. A decoder that let the keep-alive bit lose to the power-down request, or that let source 0x3 revive an oscillator that was forced off, would show the wrong enable. It checks that mode 2'b11 behaves as run and that the internal oscillator is shut only in deep sleep. A design that decoded the mode loosely would drop an enable outside deep sleep. The capture tests write new settings while the chip is in deep sleep and after it leaves, to catch a register that follows the configuration instead of latching on entry. The fallback and hazard cases are checked with the run/sleep source both set and clear, so that a swapped condition or a wrong substitute code shows up.

// File: rtl/dslp_clk_pkg.sv
package dslp_clk_pkg;
  localparam int REG_W         = 32;
  localparam int DIV_W         = 10;
  localparam int SRC_W         = 4;
  localparam int DIV_LSB       = 0;
  localparam int SRC_LSB       = 20;
  localparam int MAIN_KEEP_BIT = 30;
  localparam int INT_PD_BIT    = 31;
  localparam int SYNC_STAGES   = 2;

  localparam logic [SRC_W-1:0] SRC_MAIN = SRC_W'(3);
  localparam logic [SRC_W-1:0] SRC_INT  = SRC_W'(0);

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_DEEP  = 2'b10,
    MODE_RSVD  = 2'b11
  } pmode_e;

  typedef struct packed {
    logic             int_pd;
    logic             main_keep;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } dscfg_t;

  function automatic logic [REG_W-1:0] writable_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < DIV_W; i++) m[DIV_LSB + i] = 1'b1;
    for (int i = 0; i < SRC_W; i++) m[SRC_LSB + i] = 1'b1;
    m[MAIN_KEEP_BIT] = 1'b1;
    m[INT_PD_BIT]    = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dslp_rst_sync.sv
module dslp_rst_sync
  import dslp_clk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [SYNC_STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/dslp_cfg_reg.sv
module dslp_cfg_reg
  import dslp_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output dscfg_t           cfg,
  output logic [REG_W-1:0] rdata
);
  localparam logic [REG_W-1:0] WMASK = writable_mask();

  dscfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d.div       = wdata[DIV_LSB +: DIV_W];
    cfg_d.src       = wdata[SRC_LSB +: SRC_W];
    cfg_d.main_keep = wdata[MAIN_KEEP_BIT];
    cfg_d.int_pd    = wdata[INT_PD_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata                       = '0;
    rdata[DIV_LSB +: DIV_W]     = cfg_q.div;
    rdata[SRC_LSB +: SRC_W]     = cfg_q.src;
    rdata[MAIN_KEEP_BIT]        = cfg_q.main_keep;
    rdata[INT_PD_BIT]           = cfg_q.int_pd;
  end

  assign cfg = cfg_q;

  // R2: a write lands masked on the read port one edge later
  a_r2_write_masked: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == ($past(wdata) & WMASK)));
  // R2: without a write the word does not move
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));
endmodule

// File: rtl/dslp_osc_pwr.sv
module dslp_osc_pwr
  import dslp_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pmode_e           mode,
  input  logic             pd_req,
  input  logic             main_keep,
  input  logic             int_pd,
  input  logic [SRC_W-1:0] src,
  output logic             main_en,
  output logic             int_en
);
  logic in_deep;

  always_comb begin
    in_deep = (mode == MODE_DEEP);
    unique case ({pd_req, main_keep})
      2'b00:   main_en = !in_deep || (src == SRC_MAIN);
      2'b01:   main_en = 1'b1;
      2'b10:   main_en = 1'b0;
      default: main_en = 1'b1;
    endcase
    int_en = !(in_deep && int_pd);
  end

  // R4/R6: the keep-alive bit always wins
  a_r6_keep_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
    main_keep |-> main_en);
  // R5: a power-down request without keep-alive shuts the oscillator
  a_r5_pd_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_req && !main_keep) |-> !main_en);
  // R7: the internal oscillator is only ever shut in deep sleep
  a_r7_int_on_outside_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_DEEP) |-> int_en);
endmodule

// File: rtl/dslp_src_sel.sv
module dslp_src_sel
  import dslp_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pmode_e           mode,
  input  logic [SRC_W-1:0] src,
  input  logic [DIV_W-1:0] div,
  input  logic             int_pd,
  input  logic             rs_main,
  output logic [SRC_W-1:0] ds_src,
  output logic [DIV_W-1:0] ds_div,
  output logic             hazard
);
  logic             in_deep, entry, fallback;
  logic             prev_deep_q;
  logic [SRC_W-1:0] eff_src;
  logic [SRC_W-1:0] src_q, src_d;
  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    in_deep  = (mode == MODE_DEEP);
    entry    = in_deep && !prev_deep_q;
    fallback = (src == SRC_MAIN) && !rs_main;
    hazard   = fallback && int_pd;
    eff_src  = (fallback && !int_pd) ? SRC_INT : src;
    src_d    = entry ? eff_src : src_q;
    div_d    = entry ? div     : div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_deep_q <= 1'b0;
      src_q       <= '0;
      div_q       <= '0;
    end else begin
      prev_deep_q <= in_deep;
      src_q       <= src_d;
      div_q       <= div_d;
    end
  end

  assign ds_src = src_q;
  assign ds_div = div_q;

  // R8: staying in deep sleep never changes the captured settings
  a_r8_hold_in_deep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_deep && prev_deep_q) |=> ($stable(ds_src) && $stable(ds_div)));
  // R8: outside deep sleep the captured settings hold
  a_r8_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !in_deep |=> ($stable(ds_src) && $stable(ds_div)));
  // R9: fallback entry yields the internal oscillator code
  a_r9_fallback_int: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && src == SRC_MAIN && !rs_main && !int_pd) |=> (ds_src == SRC_INT));
  // R10: a hazardous entry keeps the main-oscillator code
  a_r10_hazard_keeps_main: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && hazard) |=> (ds_src == SRC_MAIN));
endmodule

// File: rtl/dslp_clk_ctrl.sv
module dslp_clk_ctrl
  import dslp_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [1:0]       mode_i,
  input  logic             mosc_pd_i,
  input  logic             rs_main_i,
  output logic             main_osc_en_o,
  output logic             int_osc_en_o,
  output logic [3:0]       ds_src_o,
  output logic [9:0]       ds_div_o,
  output logic             exit_hazard_o
);
  logic   rst_n_sync;
  dscfg_t cfg;
  pmode_e mode;

  assign mode = pmode_e'(mode_i);

  dslp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dslp_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  dslp_osc_pwr u_pwr (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .mode      (mode),
    .pd_req    (mosc_pd_i),
    .main_keep (cfg.main_keep),
    .int_pd    (cfg.int_pd),
    .src       (cfg.src),
    .main_en   (main_osc_en_o),
    .int_en    (int_osc_en_o)
  );

  dslp_src_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .mode    (mode),
    .src     (cfg.src),
    .div     (cfg.div),
    .int_pd  (cfg.int_pd),
    .rs_main (rs_main_i),
    .ds_src  (ds_src_o),
    .ds_div  (ds_div_o),
    .hazard  (exit_hazard_o)
  );

  // R11: the spare mode code behaves as run for the main oscillator
  a_r11_spare_is_run: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (mode_i == 2'b11 && !mosc_pd_i) |-> (main_osc_en_o && int_osc_en_o));
  // R1: the captured outputs sit at zero straight out of reset
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n_sync |-> (ds_src_o == '0 && ds_div_o == '0 && cfg_rdata == '0));
endmodule

// File: tb/test_dslp_clk_ctrl.sv
module test_dslp_clk_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [1:0]  mode_i;
  logic        mosc_pd_i, rs_main_i;
  logic        main_osc_en_o, int_osc_en_o, exit_hazard_o;
  logic [3:0]  ds_src_o;
  logic [9:0]  ds_div_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dslp_clk_ctrl i_dslp_clk_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mode_i(mode_i), .mosc_pd_i(mosc_pd_i),
    .rs_main_i(rs_main_i), .main_osc_en_o(main_osc_en_o),
    .int_osc_en_o(int_osc_en_o), .ds_src_o(ds_src_o), .ds_div_o(ds_div_o),
    .exit_hazard_o(exit_hazard_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] cfg;
    logic [1:0]  mode;
    logic        pd;
    logic        rs;
    logic        e_main;
    logic        e_int;
    logic        e_haz;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  32'h0000_0000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 run
    '{4'd3,  32'h0000_0000, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 sleep
    '{4'd3,  32'h0000_0000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 deep, src 0
    '{4'd3,  32'h0030_0000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 deep, src 3
    '{4'd3,  32'h0050_0000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 deep, src 5
    '{4'd4,  32'h4000_0000, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 deep
    '{4'd4,  32'h4000_0000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 run
    '{4'd5,  32'h0000_0000, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 run
    '{4'd5,  32'h0000_0000, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 sleep
    '{4'd5,  32'h0030_0000, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 deep, src 3
    '{4'd6,  32'h4000_0000, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 run
    '{4'd6,  32'h4000_0000, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 deep
    '{4'd6,  32'h4000_0000, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 sleep
    '{4'd7,  32'h8000_0000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 run
    '{4'd7,  32'h8000_0000, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R7 sleep
    '{4'd7,  32'h8000_0000, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 deep
    '{4'd10, 32'h8030_0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R10 run
    '{4'd10, 32'h8030_0000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R10 deep
    '{4'd10, 32'h8030_0000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R10 rs main
    '{4'd9,  32'h0030_0000, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 no hazard
    '{4'd11, 32'h0000_0000, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R11 spare main
    '{4'd11, 32'h8000_0000, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}  // R11 spare int
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_i = m;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    mode_i = 2'b00; mosc_pd_i = 1'b0; rs_main_i = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 rdata", cfg_rdata, 32'h0);
    check("R1 src", {28'h0, ds_src_o}, 32'h0);
    check("R1 div", {22'h0, ds_div_o}, 32'h0);
    check("R1 enables/haz", {29'h0, main_osc_en_o, int_osc_en_o, exit_hazard_o}, 32'h6);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 masking
    wr(32'hFFFF_FFFF);
    #2 check("R2 all ones", cfg_rdata, 32'hC0F0_03FF);
    wr(32'h3F0F_FC00);
    #2 check("R2 reserved only", cfg_rdata, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].cfg);
      mode_i = VECS[i].mode; mosc_pd_i = VECS[i].pd; rs_main_i = VECS[i].rs;
      #2;
      check($sformatf("R%0d vec %0d", VECS[i].req, i),
            {29'h0, main_osc_en_o, int_osc_en_o, exit_hazard_o},
            {29'h0, VECS[i].e_main, VECS[i].e_int, VECS[i].e_haz});
    end

    // R8 capture on entry
    mosc_pd_i = 1'b0; rs_main_i = 1'b1;
    set_mode(2'b00);
    wr(32'h0050_0123);
    set_mode(2'b10);
    check("R8 entry src", {28'h0, ds_src_o}, 32'h5);
    check("R8 entry div", {22'h0, ds_div_o}, 32'h123);
    wr(32'h0070_0055);
    #2 check("R8 write in deep", {18'h0, ds_src_o, ds_div_o}, {18'h0, 4'h5, 10'h123});
    set_mode(2'b00);
    wr(32'h0010_0011);
    #2 check("R8 after exit", {18'h0, ds_src_o, ds_div_o}, {18'h0, 4'h5, 10'h123});
    set_mode(2'b10);
    check("R8 re-entry", {18'h0, ds_src_o, ds_div_o}, {18'h0, 4'h1, 10'h011});

    // R9 fallback to internal oscillator
    set_mode(2'b00);
    rs_main_i = 1'b0;
    wr(32'h0030_0002);
    set_mode(2'b10);
    check("R9 fallback", {18'h0, ds_src_o, ds_div_o}, {18'h0, 4'h0, 10'h002});

    // R9 no fallback when main is the run/sleep source
    set_mode(2'b00);
    rs_main_i = 1'b1;
    set_mode(2'b10);
    check("R9 rs main keeps 3", {28'h0, ds_src_o}, 32'h3);

    // R10 hazard capture keeps main code
    set_mode(2'b00);
    rs_main_i = 1'b0;
    wr(32'h8030_0004);
    set_mode(2'b10);
    check("R10 hazard src", {18'h0, ds_src_o, ds_div_o}, {18'h0, 4'h3, 10'h004});
    check("R10 hazard flag", {31'h0, exit_hazard_o}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule